// File: doc/BRIEF.md
# Dual-Port Memory with Address-Collision Busy Arbitration

This block is a clocked true dual-port memory (default 1K words of 9 bits, with the word count set by a parameter up to 16K) that has two independent ports, called left and right. Each port has an active-low select, an active-low write strobe, an address, write data, registered read data, a busy output and a busy input. When both ports are selected on the same address in the same cycle, an arbiter grants one of them. It raises busy towards the other port and suppresses that port's writes. Reads from the losing port still proceed.

A mode pin sets where busy comes from. With the pin high (master), the block produces busy itself from its own address comparator and arbiter. With the pin low (slave), both busy outputs stay low and each port's busy input gates that port's writes. Several copies can then be placed side by side for a wider word, with one master copy feeding busy to the slaves.

Arbitration is first-come. A port that stayed selected on the same address since the previous cycle beats a port that has just arrived there. The holder keeps the grant for as long as the collision lasts. Simultaneous arrivals are resolved by a registered priority bit. That bit favours left after reset and afterwards favours the port that lost the last simultaneous arrival.

Top module: `dpbusy_top`

## Requirements
- R1: After reset, both busy outputs are 0, both read-data outputs are 0, and the tie priority favours the left port.
- R2: In master mode a port's busy output is 1 in a cycle exactly when both ports are selected with equal addresses and the other port holds the grant. It follows the current inputs within the same cycle, falls as soon as the addresses differ or a select goes high, and the two busy outputs are never 1 together.
- R3: A port that was selected on the same address in the previous cycle wins against a port that newly arrives at that address, whatever the priority bit says. The winner keeps the grant on every cycle while the collision continues.
- R4: When neither port or both ports were already on the address, the priority bit decides: 0 grants left, 1 grants right. It is 0 after reset, and each such tie sets it so that the loser of that tie wins the next tie.
- R5: A write from a port whose busy is active (master mode) leaves the array unchanged at that address.
- R6: At every rising edge where a port is selected, its read data register loads the array word at its address as it was before that edge's writes, whether that port is busy or not. Read data holds while the port is deselected.
- R7: A write held off by busy takes effect at the first edge where busy is low, provided the port is still selected with its write strobe low.
- R8: A word written by one port at an edge is returned to the other port by a read at the next edge.
- R9: In slave mode (mode pin 0) both busy outputs are 0, and a busy input of 1 blocks that port's writes. In master mode the busy inputs have no effect.
- R10: In slave mode, if both ports write the same address at the same edge with their busy inputs at 0, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1: busy generated internally; 0: busy taken from the busy inputs |
| lf_sel_n | input | 1 | Left port select, active low |
| lf_wr_n | input | 1 | Left port write strobe, active low |
| lf_addr | input | ADDR_W | Left port word address |
| lf_wdata | input | DATA_W | Left port write data |
| lf_rdata | output | DATA_W | Left port registered read data |
| lf_busy_o | output | 1 | Left port busy, active high, master mode only |
| lf_busy_i | input | 1 | Left port external busy, active high, slave mode only |
| rt_sel_n | input | 1 | Right port select, active low |
| rt_wr_n | input | 1 | Right port write strobe, active low |
| rt_addr | input | ADDR_W | Right port word address |
| rt_wdata | input | DATA_W | Right port write data |
| rt_rdata | output | DATA_W | Right port registered read data |
| rt_busy_o | output | 1 | Right port busy, active high, master mode only |
| rt_busy_i | input | 1 | Right port external busy, active high, slave mode only |

## Verification
The grant-stability checks assume that the mode pin does not change while a collision is in progress. The stimulus therefore switches the mode only in cycles where at least one port is deselected. All port inputs are assumed to settle well before the rising edge, because busy is a same-cycle function of them. The bench drives every input one nanosecond after an edge and samples outputs mid-cycle. Read-data comparisons are made only against words the bench has already written, so no check depends on the array's power-up contents. The directed collisions and the long mixed sequence keep addresses inside that written range.

// File: rtl/dpbusy_pkg.sv
package dpbusy_pkg;

    localparam int NPORT = 2;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

endpackage

// File: rtl/dpbusy_track.sv
module dpbusy_track #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              steady_o
);

    typedef struct packed {
        logic              act;
        logic [ADDR_W-1:0] addr;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.act  = act_i;
        if (act_i) begin
            trk_d.addr = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    // Port was already sitting on this address in the previous cycle
    assign steady_o = act_i & trk_q.act & (addr_i == trk_q.addr);

endmodule

// File: rtl/dpbusy_cmp.sv
module dpbusy_cmp #(
    parameter int ADDR_W = 10
) (
    input  logic              act_l_i,
    input  logic              act_r_i,
    input  logic [ADDR_W-1:0] addr_l_i,
    input  logic [ADDR_W-1:0] addr_r_i,
    output logic              match_o
);

    always_comb begin
        match_o = act_l_i & act_r_i & (addr_l_i == addr_r_i);
    end

endmodule

// File: rtl/dpbusy_arb.sv
module dpbusy_arb
    import dpbusy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_i,
    input  logic match_i,
    input  logic steady_l_i,
    input  logic steady_r_i,
    output logic busy_l_o,
    output logic busy_r_o
);

    typedef struct packed {
        owner_e owner;
        logic   prio_right;
        logic   past_ok;
    } arb_t;

    arb_t   st_d, st_q;
    owner_e win;
    logic   tie;

    always_comb begin
        st_d         = st_q;
        st_d.past_ok = 1'b1;
        tie          = 1'b0;
        win          = OWN_NONE;
        if (match_i) begin
            if (st_q.owner != OWN_NONE) begin
                win = st_q.owner;
            end else if (steady_l_i && !steady_r_i) begin
                win = OWN_LEFT;
            end else if (steady_r_i && !steady_l_i) begin
                win = OWN_RIGHT;
            end else begin
                tie             = 1'b1;
                win             = st_q.prio_right ? OWN_RIGHT : OWN_LEFT;
                st_d.prio_right = (win == OWN_LEFT);
            end
        end
        st_d.owner = match_i ? win : OWN_NONE;
        busy_l_o   = master_i & match_i & (win == OWN_RIGHT);
        busy_r_o   = master_i & match_i & (win == OWN_LEFT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_NONE, prio_right: 1'b0, past_ok: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R2: never both busy
    assert_busy_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_l_o, busy_r_o}));

    // R2: busy only during a collision
    assert_busy_needs_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_l_o || busy_r_o) |-> match_i);

    // R3: holder keeps the grant while the collision lasts
    assert_grant_stable_l_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.past_ok && master_i && match_i && $past(master_i && match_i && busy_r_o))
        |-> busy_r_o);

    assert_grant_stable_r_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.past_ok && master_i && match_i && $past(master_i && match_i && busy_l_o))
        |-> busy_l_o);

    // R4: every tie hands the next tie to its loser
    assert_tie_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tie |=> (st_q.prio_right != $past(st_q.prio_right)));

endmodule

// File: rtl/dpbusy_array.sv
module dpbusy_array
    import dpbusy_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NPORT-1:0]               we_i,
    input  logic [NPORT-1:0]               re_i,
    input  logic [NPORT-1:0][ADDR_W-1:0]   addr_i,
    input  logic [NPORT-1:0][DATA_W-1:0]   wdata_i,
    output logic [NPORT-1:0][DATA_W-1:0]   rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Highest port index applied first so port 0 (left) wins a same-word clash
    always_ff @(posedge clk) begin
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (we_i[p]) begin
                mem[addr_i[p]] <= wdata_i[p];
            end
        end
    end

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_rd
        logic [DATA_W-1:0] rd_d, rd_q;

        always_comb begin
            rd_d = rd_q;
            if (re_i[gp]) begin
                rd_d = mem[addr_i[gp]];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_q <= '0;
            end else begin
                rd_q <= rd_d;
            end
        end

        assign rdata_o[gp] = rd_q;
    end

endmodule

// File: rtl/dpbusy_top.sv
module dpbusy_top
    import dpbusy_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              lf_sel_n,
    input  logic              lf_wr_n,
    input  logic [ADDR_W-1:0] lf_addr,
    input  logic [DATA_W-1:0] lf_wdata,
    output logic [DATA_W-1:0] lf_rdata,
    output logic              lf_busy_o,
    input  logic              lf_busy_i,
    input  logic              rt_sel_n,
    input  logic              rt_wr_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [DATA_W-1:0] rt_wdata,
    output logic [DATA_W-1:0] rt_rdata,
    output logic              rt_busy_o,
    input  logic              rt_busy_i
);

    logic [NPORT-1:0]             act, steady, blk, wen;
    logic [NPORT-1:0][ADDR_W-1:0] addr_v;
    logic [NPORT-1:0][DATA_W-1:0] wdata_v, rdata_v;
    logic [NPORT-1:0]             wr_req, ext_busy, int_busy;
    logic                         match;

    always_comb begin
        act      = {~rt_sel_n, ~lf_sel_n};
        wr_req   = {~rt_wr_n, ~lf_wr_n};
        addr_v   = {rt_addr, lf_addr};
        wdata_v  = {rt_wdata, lf_wdata};
        ext_busy = {rt_busy_i, lf_busy_i};
    end

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
        dpbusy_track #(.ADDR_W(ADDR_W)) u_track (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (act[gp]),
            .addr_i   (addr_v[gp]),
            .steady_o (steady[gp])
        );

        // Write gating: busy source chosen by the mode pin
        always_comb begin
            blk[gp] = master_mode ? int_busy[gp] : ext_busy[gp];
            wen[gp] = act[gp] & wr_req[gp] & ~blk[gp];
        end
    end

    dpbusy_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .act_l_i  (act[0]),
        .act_r_i  (act[1]),
        .addr_l_i (addr_v[0]),
        .addr_r_i (addr_v[1]),
        .match_o  (match)
    );

    dpbusy_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_i   (master_mode),
        .match_i    (match),
        .steady_l_i (steady[0]),
        .steady_r_i (steady[1]),
        .busy_l_o   (int_busy[0]),
        .busy_r_o   (int_busy[1])
    );

    dpbusy_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wen),
        .re_i    (act),
        .addr_i  (addr_v),
        .wdata_i (wdata_v),
        .rdata_o (rdata_v)
    );

    assign lf_busy_o = int_busy[0];
    assign rt_busy_o = int_busy[1];
    assign lf_rdata  = rdata_v[0];
    assign rt_rdata  = rdata_v[1];

    // R5: a busy port never reaches the array in master mode
    assert_busy_blocks_l_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && lf_busy_o) |-> !wen[0]);

    assert_busy_blocks_r_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && rt_busy_o) |-> !wen[1]);

    // R9: slave copies never drive busy
    assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (!lf_busy_o && !rt_busy_o));

endmodule

// File: tb/tb_dpbusy_top.sv
`timescale 1ns/1ps
module tb_dpbusy_top;

    localparam int AW = 10;
    localparam int DW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b1;
    logic sl = 0, wl = 0, sr = 0, wr = 0, bil = 0, bir = 0;
    logic [AW-1:0] al = '0, ar = '0;
    logic [DW-1:0] dl = '0, dr = '0;
    logic [DW-1:0] lf_rdata, rt_rdata;
    logic lf_busy_o, rt_busy_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // Reference model state
    int m_own = 0;          // 0 none, 1 left, 2 right
    int m_prio = 0;         // 0 favours left
    int p_act[2] = '{0, 0};
    int p_addr[2] = '{0, 0};
    int mem[int];
    int rexp[2] = '{0, 0};
    bit rknown[2] = '{1, 1};

    always #2.5 clk = ~clk;

    dpbusy_top #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .master_mode(mode),
        .lf_sel_n(~sl), .lf_wr_n(~wl), .lf_addr(al), .lf_wdata(dl),
        .lf_rdata(lf_rdata), .lf_busy_o(lf_busy_o), .lf_busy_i(bil),
        .rt_sel_n(~sr), .rt_wr_n(~wr), .rt_addr(ar), .rt_wdata(dr),
        .rt_rdata(rt_rdata), .rt_busy_o(rt_busy_o), .rt_busy_i(bir)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive inputs just after an edge, then let them settle
    task automatic drv(input bit s0, input bit w0, input int a0, input int d0,
                       input bit s1, input bit w1, input int a1, input int d1);
        sl = s0; wl = w0; al = AW'(a0); dl = DW'(d0);
        sr = s1; wr = w1; ar = AW'(a1); dr = DW'(d1);
        #1;
    endtask

    task automatic idle();
        drv(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // Model one cycle: compare outputs mid-cycle, then advance at the edge
    task automatic tick();
        int a0, a1, win, eb0, eb1, blk0, blk1;
        bit match, st0, st1;
        a0 = int'(al); a1 = int'(ar);
        match = sl && sr && (a0 == a1);
        st0 = sl && p_act[0] != 0 && p_addr[0] == a0;
        st1 = sr && p_act[1] != 0 && p_addr[1] == a1;
        win = 0;
        if (match) begin
            if (m_own != 0) win = m_own;
            else if (st0 && !st1) win = 1;
            else if (st1 && !st0) win = 2;
            else win = (m_prio != 0) ? 2 : 1;
        end
        eb0 = (mode && match && win == 2) ? 1 : 0;
        eb1 = (mode && match && win == 1) ? 1 : 0;
        chk("R2 left busy", int'(lf_busy_o), eb0);
        chk("R2 right busy", int'(rt_busy_o), eb1);
        if (rknown[0]) chk("R6 left rdata", int'(lf_rdata), rexp[0]);
        if (rknown[1]) chk("R6 right rdata", int'(rt_rdata), rexp[1]);
        blk0 = mode ? eb0 : int'(bil);
        blk1 = mode ? eb1 : int'(bir);
        @(posedge clk);
        if (sl) begin
            rknown[0] = mem.exists(a0);
            if (rknown[0]) rexp[0] = mem[a0];
        end
        if (sr) begin
            rknown[1] = mem.exists(a1);
            if (rknown[1]) rexp[1] = mem[a1];
        end
        if (sr && wr && blk1 == 0) mem[a1] = int'(dr);
        if (sl && wl && blk0 == 0) mem[a0] = int'(dl);
        if (match && m_own == 0 && st0 == st1) m_prio = (win == 1) ? 1 : 0;
        m_own = match ? win : 0;
        p_act[0] = sl; p_act[1] = sr;
        if (sl) p_addr[0] = a0;
        if (sr) p_addr[1] = a1;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 left busy", int'(lf_busy_o), 0);
        chk("R1 right busy", int'(rt_busy_o), 0);
        chk("R1 left rdata", int'(lf_rdata), 0);
        chk("R1 right rdata", int'(rt_rdata), 0);
        @(posedge clk); #1;

        // Fill addresses 0..15 and 32..47 without collisions
        for (int i = 0; i < 16; i++) begin
            drv(1, 1, i, 100 + i, 1, 1, 32 + i, 200 + i);
            tick();
        end

        // R8: left writes 5, right reads it one edge later
        drv(1, 1, 5, 9'h1AA, 1, 0, 6, 0); tick();
        drv(0, 0, 0, 0, 1, 0, 5, 0); tick();
        idle();
        chk("R8 port-to-port read", int'(rt_rdata), 9'h1AA);
        tick();
        idle();
        chk("R6 rdata holds while deselected", int'(rt_rdata), 9'h1AA);
        tick();

        // R4: simultaneous arrival, priority favours left after reset (R1)
        drv(1, 1, 3, 9'h033, 1, 1, 3, 9'h0CC);
        chk("R4 first tie right busy", int'(rt_busy_o), 1);
        chk("R4 first tie left free", int'(lf_busy_o), 0);
        tick();
        drv(1, 1, 3, 9'h033, 1, 1, 3, 9'h0CC);
        chk("R3 holder keeps grant", int'(rt_busy_o), 1);
        tick();
        drv(0, 0, 0, 0, 1, 1, 3, 9'h0CC);
        chk("R5 loser write absent, loser read allowed", int'(rt_rdata), 9'h033);
        chk("R2 busy drops on deselect", int'(rt_busy_o), 0);
        tick();
        drv(1, 0, 3, 0, 0, 0, 0, 0); tick();
        idle();
        chk("R7 held-off write completed", int'(lf_rdata), 9'h0CC);
        tick();

        // R4: next tie goes to the previous loser
        drv(1, 1, 4, 9'h044, 1, 1, 4, 9'h0BB);
        chk("R4 flipped tie left busy", int'(lf_busy_o), 1);
        chk("R4 flipped tie right free", int'(rt_busy_o), 0);
        tick();
        idle(); tick();

        // R3: earlier arrival beats priority (priority now favours left)
        drv(0, 0, 0, 0, 1, 0, 9, 0); tick();
        drv(1, 1, 9, 9'h099, 1, 0, 9, 0);
        chk("R3 earlier arrival wins", int'(lf_busy_o), 1);
        tick();
        drv(1, 1, 10, 9'h010, 1, 0, 9, 0);
        chk("R2 busy drops on address change", int'(lf_busy_o), 0);
        tick();
        idle();
        chk("R5 blocked write left word intact", int'(rt_rdata), 109);
        tick();

        // R9: slave mode
        mode = 1'b0; bil = 1'b1; bir = 1'b0;
        drv(1, 1, 12, 9'h1F0, 1, 0, 12, 0);
        chk("R9 slave left busy low", int'(lf_busy_o), 0);
        chk("R9 slave right busy low", int'(rt_busy_o), 0);
        tick();
        drv(0, 0, 0, 0, 1, 0, 12, 0); tick();
        idle();
        chk("R9 busy input blocked write", int'(rt_rdata), 112);
        tick();

        // R10: slave-mode same-word double write
        bil = 1'b0; bir = 1'b0;
        drv(1, 1, 13, 9'h1A1, 1, 1, 13, 9'h0B2); tick();
        drv(1, 0, 13, 0, 0, 0, 0, 0); tick();
        idle();
        chk("R10 left data kept", int'(lf_rdata), 9'h1A1);
        tick();

        // R9: master mode ignores busy inputs
        mode = 1'b1; bil = 1'b1; bir = 1'b1;
        drv(1, 1, 14, 9'h0EE, 0, 0, 0, 0); tick();
        drv(1, 0, 14, 0, 0, 0, 0, 0); tick();
        idle();
        chk("R9 busy input ignored in master", int'(lf_rdata), 9'h0EE);
        tick();
        bil = 1'b0; bir = 1'b0;

        // Mixed traffic on a small address set, compared every cycle
        for (int k = 0; k < 400; k++) begin
            drv($urandom_range(0, 3) != 0, $urandom_range(0, 1) != 0,
                $urandom_range(0, 3), $urandom_range(0, 511),
                $urandom_range(0, 3) != 0, $urandom_range(0, 1) != 0,
                $urandom_range(0, 3), $urandom_range(0, 511));
            tick();
        end
        idle(); tick();

        finish_run();
    end

endmodule